// File: doc/BRIEF.md
# Cycle-Synchronized Fail Signature Comparator

This block watches a small group of device output pins while a test program runs. It decides whether the device reproduced a known failing signature. Before testing, a reference list is written into the block. Each entry names one test cycle and the pin-state vector expected at that cycle. An external per-cycle strobe, which may be asynchronous to the block clock, advances a cycle counter. On each strobe the current pin states are captured together with the cycle number. A comparator drains the captured entries and checks only those whose cycle number appears in the reference list. All other cycles are ignored.

At the end of each test run the block makes its decision. It emits a one-clock trigger pulse only if every reference entry was checked and none of them mismatched. If the run ended before every listed cycle was reached, or the capture buffer overflowed, the trigger is held off and an error flag is raised. One run is made per stimulation position. A run-start input rewinds the block between runs and keeps the reference list intact.

Top module: `sigcmp_top`

## Requirements
- R1: After reset, `trigger` and `err` are 0 and the reference list is empty.
- R2: Each rising edge of `strobe_in`, after a two-flop synchronizer, is one test cycle. The first rising edge after `run_start` is cycle 0, and later edges count up by one. `pins_in` is sampled on the clock where the edge is detected.
- R3: When `run_end` is pulsed, every reference entry has been checked and none mismatched, `trigger` is high for exactly one clock. That clock follows the `run_end` clock by one, provided the capture buffer has drained.
- R4: If the captured pins at any listed cycle differ from the expected vector in any bit, no trigger is produced for that run and `err` stays 0.
- R5: Pin values at cycles that are not in the reference list have no effect on the decision.
- R6: If `run_end` arrives before every listed cycle has been reached, no trigger is produced and `err` becomes 1.
- R7: `run_start` clears `err`, the cycle counter, the capture buffer and the mismatch state, and rewinds the reference list. The reference contents are kept for the next run.
- R8: A strobe held high for many clocks counts as a single cycle.
- R9: With an empty reference list, every run end yields a trigger pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_wr_en | input | 1 | Append one entry to the reference list |
| ref_wr_cycle | input | 16 | Cycle number of the entry being appended |
| ref_wr_pins | input | 8 | Expected pin vector of the entry being appended |
| run_start | input | 1 | Begin a new test run |
| run_end | input | 1 | Request the pass/fail decision for the current run |
| strobe_in | input | 1 | Asynchronous once-per-test-cycle strobe |
| pins_in | input | 8 | Monitored device output pins |
| trigger | output | 1 | One-clock match pulse toward the image processor |
| err | output | 1 | Run ended early or capture overflowed |

## Verification
The checks assume that reference entries are written in strictly ascending cycle order. They also assume that `pins_in` stays steady while a strobe passes through the synchronizer, and that `run_end` comes only after the capture buffer has drained. The bench keeps to these conditions. It holds the pins for a whole strobe period, spaces strobes several clocks apart, and waits a few idle clocks before pulsing `run_end`. The assertions also take as given that strobes never arrive faster than the comparator drains entries, so the capture buffer never fills.

// File: rtl/sigcmp_pkg.sv
package sigcmp_pkg;
    localparam int CYC_W = 16;
    localparam int PIN_W = 8;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [PIN_W-1:0] pins;
    } cap_entry_t;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [PIN_W-1:0] expect_pins;
    } ref_entry_t;

    localparam int ENTRY_W = $bits(cap_entry_t);

    function automatic logic same_cycle(cap_entry_t c, ref_entry_t r);
        return c.cyc == r.cyc;
    endfunction

    function automatic logic pins_differ(cap_entry_t c, ref_entry_t r);
        return c.pins != r.expect_pins;
    endfunction
endpackage

// File: rtl/sigcmp_strobe_sync.sv
module sigcmp_strobe_sync (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic strobe_rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= strobe_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign strobe_rise = sync_q & ~prev_q;
endmodule

// File: rtl/sigcmp_cap_fifo.sv
module sigcmp_cap_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      fill;

    assign empty = (fill == '0);
    assign full  = (fill == (AW+1)'(DEPTH));
    assign dout  = mem[rp];

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/sigcmp_ref_store.sv
module sigcmp_ref_store
    import sigcmp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ref_entry_t wr_entry,
    input  logic       rewind,
    input  logic       advance,
    output ref_entry_t head,
    output logic       all_done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ref_entry_t  mem [DEPTH];
    logic [AW:0] wr_cnt, rd_idx;

    assign all_done = (rd_idx == wr_cnt);
    assign head     = mem[rd_idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && wr_cnt < (AW+1)'(DEPTH)) mem[wr_cnt[AW-1:0]] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt <= '0;
            rd_idx <= '0;
        end else begin
            if (wr_en && wr_cnt < (AW+1)'(DEPTH)) wr_cnt <= wr_cnt + 1'b1;
            if (rewind)                           rd_idx <= '0;
            else if (advance && !all_done)        rd_idx <= rd_idx + 1'b1;
        end
    end
endmodule

// File: rtl/sigcmp_top.sv
module sigcmp_top
    import sigcmp_pkg::*;
#(
    parameter int REF_DEPTH = 16,
    parameter int CAP_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_wr_en,
    input  logic [CYC_W-1:0] ref_wr_cycle,
    input  logic [PIN_W-1:0] ref_wr_pins,
    input  logic             run_start,
    input  logic             run_end,
    input  logic             strobe_in,
    input  logic [PIN_W-1:0] pins_in,
    output logic             trigger,
    output logic             err
);
    logic             strobe_rise;
    logic [CYC_W-1:0] cyc_q;
    logic             cap_push, cap_pop, cap_empty, cap_full;
    cap_entry_t       cap_in, cap_head;
    logic [ENTRY_W-1:0] cap_raw;
    ref_entry_t       ref_head, ref_wr;
    logic             ref_done, ref_adv;
    logic             mism_q, ovf_q, pend_q, err_q, trig_q;

    sigcmp_strobe_sync u_sync (
        .clk(clk), .rst(rst), .strobe_async(strobe_in), .strobe_rise(strobe_rise)
    );

    assign cap_push    = strobe_rise && !run_start;
    assign cap_in.cyc  = cyc_q;
    assign cap_in.pins = pins_in;

    sigcmp_cap_fifo #(.WIDTH(ENTRY_W), .DEPTH(CAP_DEPTH)) u_cap (
        .clk(clk), .rst(rst), .flush(run_start),
        .push(cap_push), .din(cap_in),
        .pop(cap_pop), .dout(cap_raw),
        .empty(cap_empty), .full(cap_full)
    );
    assign cap_head = cap_entry_t'(cap_raw);

    assign ref_wr.cyc         = ref_wr_cycle;
    assign ref_wr.expect_pins = ref_wr_pins;

    sigcmp_ref_store #(.DEPTH(REF_DEPTH)) u_ref (
        .clk(clk), .rst(rst), .wr_en(ref_wr_en), .wr_entry(ref_wr),
        .rewind(run_start), .advance(ref_adv),
        .head(ref_head), .all_done(ref_done)
    );

    // Comparator: one captured entry is retired per clock.
    assign cap_pop = !cap_empty && !run_start;
    assign ref_adv = cap_pop && !ref_done && same_cycle(cap_head, ref_head);

    wire decide  = pend_q && cap_empty;
    wire pass_ok = !mism_q && ref_done && !ovf_q && !err_q;

    always_ff @(posedge clk) begin
        if (rst || run_start) begin
            cyc_q  <= '0;
            mism_q <= 1'b0;
            ovf_q  <= 1'b0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            if (strobe_rise)              cyc_q  <= cyc_q + 1'b1;
            if (cap_push && cap_full)     ovf_q  <= 1'b1;
            if (ref_adv && pins_differ(cap_head, ref_head)) mism_q <= 1'b1;
            trig_q <= 1'b0;
            if (decide) begin
                pend_q <= 1'b0;
                trig_q <= pass_ok;
                err_q  <= err_q | !ref_done | ovf_q;
            end else if (run_end) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign trigger = trig_q;
    assign err     = err_q;
endmodule

// File: rtl/sigcmp_chk.sv
module sigcmp_chk (
    input logic clk,
    input logic rst,
    input logic run_start,
    input logic trigger,
    input logic err,
    input logic pend,
    input logic cap_push,
    input logic cap_full
);
    // R3: trigger is a single-clock pulse
    p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        trigger |=> !trigger);

    // R3: trigger only follows a pending run-end request
    p_after_end_r3: assert property (@(posedge clk) disable iff (rst)
        trigger |-> $past(pend));

    // R6: a run flagged in error never triggers
    p_clean_r6: assert property (@(posedge clk) disable iff (rst)
        trigger |-> !err);

    // R7: run start clears the outputs
    p_start_clear_r7: assert property (@(posedge clk) disable iff (rst)
        run_start |=> (!err && !trigger));

    // R2: capture never pushes into a full buffer
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        !(cap_push && cap_full));
endmodule

bind sigcmp_top sigcmp_chk u_chk (
    .clk(clk), .rst(rst), .run_start(run_start),
    .trigger(trigger), .err(err), .pend(pend_q),
    .cap_push(cap_push), .cap_full(cap_full)
);

// File: tb/sigcmp_top_bench.sv
module sigcmp_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_wr_en = 1'b0;
    logic [15:0] ref_wr_cycle = '0;
    logic [7:0]  ref_wr_pins = '0;
    logic        run_start = 1'b0;
    logic        run_end = 1'b0;
    logic        strobe_in = 1'b0;
    logic [7:0]  pins_in = '0;
    logic        trigger, err;

    int checks = 0;
    int errors = 0;
    int listed [4] = '{0, 5, 6, 11};
    bit ref_loaded = 1'b0;

    always #2.5 clk = ~clk;

    sigcmp_top u_sigcmp_top (
        .clk(clk), .rst(rst), .ref_wr_en(ref_wr_en), .ref_wr_cycle(ref_wr_cycle),
        .ref_wr_pins(ref_wr_pins), .run_start(run_start), .run_end(run_end),
        .strobe_in(strobe_in), .pins_in(pins_in), .trigger(trigger), .err(err)
    );

    function automatic logic [7:0] pin_at(int c);
        return 8'((c * 37 + 5) & 8'hFF);
    endfunction

    function automatic bit is_listed(int c);
        foreach (listed[i]) if (listed[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_ref();
        foreach (listed[i]) begin
            @(negedge clk);
            ref_wr_en    = 1'b1;
            ref_wr_cycle = 16'(listed[i]);
            ref_wr_pins  = pin_at(listed[i]);
        end
        @(negedge clk);
        ref_wr_en = 1'b0;
        ref_loaded = 1'b1;
    endtask

    // n cycles; pins at cycle bad_c are XORed with bad_mask; hold = strobe high clocks
    task automatic do_run(int n, int bad_c, logic [7:0] bad_mask, int hold, string req);
        int  trig_cnt;
        bit  mism, complete, exp_trig, exp_err;
        @(negedge clk);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        chk(err == 1'b0, "R7", err, 0);
        clocks(2);
        for (int c = 0; c < n; c++) begin
            pins_in = pin_at(c) ^ ((c == bad_c) ? bad_mask : 8'h00);
            clocks(1);
            strobe_in = 1'b1;
            clocks(hold);
            strobe_in = 1'b0;
            clocks(4);
        end
        clocks(4);
        run_end = 1'b1;
        @(negedge clk);
        run_end = 1'b0;
        trig_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (trigger) trig_cnt++;
        end
        mism     = ref_loaded && is_listed(bad_c) && bad_c < n && bad_mask != 0;
        complete = !ref_loaded || n >= 12;
        exp_trig = complete && !mism;
        exp_err  = !complete;
        chk(trig_cnt == (exp_trig ? 1 : 0), req, trig_cnt, exp_trig ? 1 : 0);
        chk(err == exp_err, req, err, exp_err);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clocks(3);
        rst = 1'b0;
        clocks(1);
        chk(trigger == 1'b0, "R1", trigger, 0);
        chk(err == 1'b0, "R1", err, 0);

        // R9: empty reference list
        do_run(3, -1, 8'h00, 3, "R9");

        load_ref();
        // R3, R2: full clean run (cycle 0 listed)
        do_run(14, -1, 8'h00, 3, "R3");
        // R4: one flipped bit at each listed cycle
        foreach (listed[i])
            for (int b = 0; b < 8; b++)
                do_run(14, listed[i], 8'(1 << b), 3, "R4");
        // R5: corruption at unlisted cycles
        for (int c = 0; c < 14; c++)
            if (!is_listed(c)) do_run(14, c, 8'hFF, 3, "R5");
        // R6: runs ending before the last listed cycle
        for (int n = 0; n < 12; n++)
            do_run(n, -1, 8'h00, 3, "R6");
        // R8: long strobe counts once
        do_run(14, -1, 8'h00, 20, "R8");
        // R2: numbering restarts after run_start (R7)
        do_run(14, 5, 8'h01, 3, "R2");
        do_run(14, -1, 8'h00, 3, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule